// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-side register front end of a three-channel interval timer. A host reaches it over an 8-bit data bus with a 2-bit address, a select and separate read and write strobes. Addresses 0 to 2 reach the count registers of channels 0 to 2. Address 3 reaches the control register. Control words set each channel's counting mode and its byte access pattern. They also issue snapshot commands. The counting engines are outside this block. Each engine receives a one-cycle load pulse with a 16-bit count. It returns its live count, its output level and a pulse that marks the moment it has taken a newly written count.

Counts are 16 bits wide, but the bus carries one byte at a time. A channel can use the low byte only, the high byte only, or the low byte followed by the high byte. A host that reads a counter while it is running can first freeze a snapshot, so that the two byte reads give the halves of one value. A status byte can be frozen the same way. The status byte shows the channel's output level, whether the last written count is still waiting to reach the counting engine, and the channel's configuration.

Top module: `tmr_cpu_if`

## Requirements
- R1: After reset, `rdata` is 0, `mode_o` is 0 and no load pulse appears.
- R2: A write to address 3 with bits 7:6 ≠ 3 and bits 5:4 ≠ 0 configures the channel in bits 7:6. It stores the access code (bits 5:4), the mode (bits 3:1, which appear on that channel's 3-bit slice of `mode_o`) and the BCD bit (bit 0). The other channels' slices do not change.
- R3: A data write to a channel that has not been configured since reset causes no load pulse.
- R4: With access code 01 a single data write loads `{8'h00, byte}`. With access code 10 it loads `{byte, 8'h00}`. The load pulse on `ld_o[ch]` lasts one cycle, starts the cycle after the write, and carries the value on `ld_val_o`.
- R5: With access code 11 the first data write loads nothing. The second data write loads `{second, first}`. The two writes then alternate in this way.
- R6: Reads of a channel return bytes of its live count. Access code 01 returns the low byte and access code 10 returns the high byte. Access code 11 returns the low byte and the high byte alternately, starting with the low byte.
- R7: A control word with access code 00 freezes the named channel's count. The following reads return bytes of the frozen value, even while the live count changes. The freeze ends after the high byte is read with access code 11, or after one read in single-byte access.
- R8: A second freeze command for a channel whose snapshot has not yet been fully read is ignored.
- R9: Configuring a channel again resets both its read and write byte order to the low byte and drops any pending count or status snapshot.
- R10: The status byte is {output level, null flag, access[1:0], mode[2:0], BCD}, with bit 7 as the MSB. The null flag is set by configuring the channel or by a count load. It is cleared by `loaded_i`.
- R11: A control word with bits 7:6 = 11 is a multi-channel command. Bit 5 freezes the count, bit 4 freezes the status, and bits 3, 2 and 1 select channels 2, 1 and 0. A frozen status is returned by the next read before any count byte, and that read does not move the count byte order.
- R12: `rdata` is registered. It changes only in the cycle after a selected read. A read of address 3 returns 0. Strobes without `sel` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Block select |
| rd | input | 1 | Read strobe, one byte per cycle |
| wr | input | 1 | Write strobe, one byte per cycle |
| addr | input | 2 | 0..2 channel count registers, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ld_o | output | NCH | Per-channel count load pulse |
| ld_val_o | output | NCH*16 | Per-channel count to load |
| mode_o | output | NCH*3 | Per-channel mode field |
| cnt_i | input | NCH*16 | Per-channel live count |
| out_i | input | NCH | Per-channel output level |
| loaded_i | input | NCH | Per-channel count-taken pulse |

## Verification
Most internal state in this block appears at the ports only through later traffic. A byte pointer that has flipped by mistake shows up at the next read or write of that channel, as swapped halves or as a load pulse that is missing or comes early. A snapshot that is held too long or released too early appears as a stale or live byte on the first read after the live count changes. The tests therefore change the live count between the freeze and the reads. A wrong null flag or a wrong stored configuration appears only when a status snapshot is read, so the status byte is read both before and after a `loaded_i` pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_PAIR  = 2'b11
  } acc_e;

  localparam logic [1:0] CTL_ADDR = 2'd3;
  localparam logic [1:0] MULTI_CH = 2'd3;
endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode #(
  parameter int NCH = 3
) (
  input  logic           ctl_we,
  input  logic [7:0]     cw,
  output logic [NCH-1:0] cfg_we,
  output logic [NCH-1:0] lat_cnt,
  output logic [NCH-1:0] lat_sts
);
  import tmr_pkg::*;

  always_comb begin
    cfg_we  = '0;
    lat_cnt = '0;
    lat_sts = '0;
    if (ctl_we) begin
      for (int i = 0; i < NCH; i++) begin
        if (cw[7:6] == MULTI_CH) begin
          if (cw[i+1]) begin
            lat_cnt[i] = cw[5];
            lat_sts[i] = cw[4];
          end
        end else if (cw[7:6] == i[1:0]) begin
          if (cw[5:4] == ACC_LATCH) lat_cnt[i] = 1'b1;
          else                      cfg_we[i]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs #(
  parameter int DW = 8,
  parameter int MW = 3,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [7:0]    cw,
  input  logic          lat_cnt,
  input  logic          lat_sts,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cnt_i,
  input  logic          out_i,
  input  logic          loaded_i,
  output logic          ld_o,
  output logic [CW-1:0] ld_val_o,
  output logic [MW-1:0] mode_o,
  output logic [DW-1:0] rbyte
);
  import tmr_pkg::*;

  acc_e          acc;
  logic          cfg_ok, bcd, wptr, rptr, null_f;
  logic [DW-1:0] lo_hold;
  logic          cnt_lat_v, sts_lat_v;
  logic [CW-1:0] cnt_lat;
  logic [7:0]    sts_lat;
  logic [7:0]    sts_live;
  logic [CW-1:0] src;

  assign sts_live = {out_i, null_f, acc, mode_o, bcd};
  assign src      = cnt_lat_v ? cnt_lat : cnt_i;

  always_comb begin
    rbyte = '0;
    if (sts_lat_v) rbyte = sts_lat;
    else begin
      case (acc)
        ACC_LO:   rbyte = src[DW-1:0];
        ACC_HI:   rbyte = src[CW-1:DW];
        ACC_PAIR: rbyte = rptr ? src[CW-1:DW] : src[DW-1:0];
        default:  rbyte = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= ACC_LATCH; mode_o <= '0; bcd <= 1'b0; cfg_ok <= 1'b0;
      wptr <= 1'b0; rptr <= 1'b0; null_f <= 1'b0; lo_hold <= '0;
      cnt_lat_v <= 1'b0; sts_lat_v <= 1'b0; cnt_lat <= '0; sts_lat <= '0;
      ld_o <= 1'b0; ld_val_o <= '0;
    end else begin
      ld_o <= 1'b0;
      if (cfg_we) begin
        cfg_ok <= 1'b1;
        acc    <= acc_e'(cw[5:4]);
        mode_o <= cw[3:1];
        bcd    <= cw[0];
        wptr <= 1'b0; rptr <= 1'b0;
        cnt_lat_v <= 1'b0; sts_lat_v <= 1'b0;
        null_f <= 1'b1;
      end else begin
        if (lat_cnt && cfg_ok && !cnt_lat_v) begin
          cnt_lat_v <= 1'b1;
          cnt_lat   <= cnt_i;
        end
        if (lat_sts && cfg_ok && !sts_lat_v) begin
          sts_lat_v <= 1'b1;
          sts_lat   <= sts_live;
        end
        if (loaded_i) null_f <= 1'b0;
        if (data_we && cfg_ok) begin
          case (acc)
            ACC_LO: begin
              ld_o <= 1'b1; ld_val_o <= {{DW{1'b0}}, wdata}; null_f <= 1'b1;
            end
            ACC_HI: begin
              ld_o <= 1'b1; ld_val_o <= {wdata, {DW{1'b0}}}; null_f <= 1'b1;
            end
            ACC_PAIR: begin
              if (!wptr) begin
                lo_hold <= wdata; wptr <= 1'b1;
              end else begin
                ld_o <= 1'b1; ld_val_o <= {wdata, lo_hold};
                wptr <= 1'b0; null_f <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (data_re) begin
          if (sts_lat_v) sts_lat_v <= 1'b0;
          else begin
            if (acc == ACC_PAIR) rptr <= ~rptr;
            if (cnt_lat_v && (acc != ACC_PAIR || rptr)) cnt_lat_v <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_cpu_if.sv
module tmr_cpu_if #(
  parameter int NCH = 3,
  parameter int DW  = 8,
  parameter int MW  = 3,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NCH-1:0]    ld_o,
  output logic [NCH*CW-1:0] ld_val_o,
  output logic [NCH*MW-1:0] mode_o,
  input  logic [NCH*CW-1:0] cnt_i,
  input  logic [NCH-1:0]    out_i,
  input  logic [NCH-1:0]    loaded_i
);
  import tmr_pkg::*;

  logic                   ctl_we;
  logic [NCH-1:0]         cfg_we, lat_cnt, lat_sts;
  logic [NCH-1:0][DW-1:0] rbyte;
  logic [DW-1:0]          rsel;

  assign ctl_we = sel && wr && (addr == CTL_ADDR);

  tmr_cw_decode #(.NCH(NCH)) u_dec (
    .ctl_we (ctl_we),
    .cw     (wdata[7:0]),
    .cfg_we (cfg_we),
    .lat_cnt(lat_cnt),
    .lat_sts(lat_sts)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan_regs #(.DW(DW), .MW(MW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .cfg_we  (cfg_we[g]),
      .cw      (wdata[7:0]),
      .lat_cnt (lat_cnt[g]),
      .lat_sts (lat_sts[g]),
      .data_we (sel && wr && (addr == g)),
      .data_re (sel && rd && (addr == g)),
      .wdata   (wdata),
      .cnt_i   (cnt_i[g*CW +: CW]),
      .out_i   (out_i[g]),
      .loaded_i(loaded_i[g]),
      .ld_o    (ld_o[g]),
      .ld_val_o(ld_val_o[g*CW +: CW]),
      .mode_o  (mode_o[g*MW +: MW]),
      .rbyte   (rbyte[g])
    );
  end

  always_comb begin
    rsel = '0;
    for (int i = 0; i < NCH; i++)
      if (addr == i[1:0]) rsel = rbyte[i];
  end

  always_ff @(posedge clk) begin
    if (rst)              rdata <= '0;
    else if (sel && rd)   rdata <= (addr == CTL_ADDR) ? '0 : rsel;
  end
endmodule

// File: rtl/tmr_if_checker.sv
module tmr_if_checker #(
  parameter int NCH = 3,
  parameter int DW  = 8,
  parameter int MW  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              rd,
  input logic              wr,
  input logic [1:0]        addr,
  input logic [DW-1:0]     rdata,
  input logic [NCH-1:0]    ld_o,
  input logic [NCH*MW-1:0] mode_o
);
  p_ld_src_r4: assert property (@(posedge clk) disable iff (rst)
    (|ld_o) |-> $past(sel && wr && addr != 2'd3));

  p_idle_no_ld_r3: assert property (@(posedge clk) disable iff (rst)
    !(sel && wr) |=> (ld_o == '0));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !(sel && rd) |=> $stable(rdata));

  p_ctl_read_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (sel && rd && addr == 2'd3) |=> (rdata == '0));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(sel && wr && addr == 2'd3) |=> $stable(mode_o));
endmodule

bind tmr_cpu_if tmr_if_checker #(.NCH(NCH), .DW(DW), .MW(MW)) u_chk (.*);

// File: tb/tmr_cpu_if_bench.sv
module tmr_cpu_if_bench;
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]        addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic [NCH-1:0]    ld_o;
  logic [NCH*CW-1:0] ld_val_o;
  logic [NCH*3-1:0]  mode_o;
  logic [NCH*CW-1:0] cnt_i = '0;
  logic [NCH-1:0]    out_i = '0;
  logic [NCH-1:0]    loaded_i = '0;

  int checks = 0, errors = 0;
  int ld_cnt [NCH];
  logic [15:0] ld_last [NCH];

  always #2 clk = ~clk;

  tmr_cpu_if u_tmr_cpu_if (.*);

  initial for (int i = 0; i < NCH; i++) begin ld_cnt[i] = 0; ld_last[i] = '0; end

  always @(posedge clk)
    for (int i = 0; i < NCH; i++)
      if (!rst && ld_o[i]) begin
        ld_cnt[i]++;
        ld_last[i] = ld_val_o[i*CW +: CW];
      end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    @(negedge clk); sel = 0; rd = 0; d = rdata;
  endtask

  task automatic set_cnt(int ch, logic [15:0] v);
    cnt_i[ch*CW +: CW] = v;
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 loads", ld_cnt[0] + ld_cnt[1] + ld_cnt[2], 0);
  endtask

  task automatic t_unconfigured;
    bus_wr(2'd1, 8'h55); @(negedge clk);
    chk("R3 no load before control word", ld_cnt[1], 0);
  endtask

  task automatic t_single_byte;
    bus_wr(2'd3, 8'h14);
    chk("R2 mode ch0", mode_o, 9'o002);
    bus_wr(2'd0, 8'h34); @(negedge clk);
    chk("R4 lsb-only count", ld_cnt[0], 1);
    chk("R4 lsb-only value", ld_last[0], 16'h0034);
    bus_wr(2'd3, 8'hA6);
    chk("R2 mode ch2 others kept", mode_o, 9'o302);
    bus_wr(2'd2, 8'h12); @(negedge clk);
    chk("R4 msb-only value", ld_last[2], 16'h1200);
  endtask

  task automatic t_pair;
    bus_wr(2'd3, 8'h78);
    chk("R2 mode ch1", mode_o, 9'o342);
    bus_wr(2'd1, 8'hCD); @(negedge clk);
    chk("R5 no load after first byte", ld_cnt[1], 0);
    bus_wr(2'd1, 8'hAB); @(negedge clk);
    chk("R5 load after second byte", ld_cnt[1], 1);
    chk("R5 pair value", ld_last[1], 16'hABCD);
  endtask

  task automatic t_live_read;
    logic [7:0] d;
    set_cnt(1, 16'h1234); set_cnt(0, 16'h5678); set_cnt(2, 16'h9ABC);
    bus_rd(2'd1, d); chk("R6 pair low first", d, 8'h34);
    bus_rd(2'd1, d); chk("R6 pair high second", d, 8'h12);
    bus_rd(2'd0, d); chk("R6 lsb-only read", d, 8'h78);
    bus_rd(2'd2, d); chk("R6 msb-only read", d, 8'h9A);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    set_cnt(1, 16'h1357);
    bus_wr(2'd3, 8'h40);
    set_cnt(1, 16'h2468);
    bus_wr(2'd3, 8'h40);
    bus_rd(2'd1, d); chk("R7 frozen low / R8 second latch ignored", d, 8'h57);
    set_cnt(1, 16'hF0F0);
    bus_rd(2'd1, d); chk("R7 frozen high", d, 8'h13);
    bus_rd(2'd1, d); chk("R7 released to live", d, 8'hF0);
  endtask

  task automatic t_reconfig;
    logic [7:0] d;
    set_cnt(1, 16'h4321);
    bus_wr(2'd3, 8'h40);
    set_cnt(1, 16'h8765);
    bus_wr(2'd3, 8'h78);
    bus_rd(2'd1, d); chk("R9 latch dropped, pointer reset", d, 8'h65);
    bus_wr(2'd1, 8'hEE);
    bus_wr(2'd3, 8'h78);
    bus_wr(2'd1, 8'h22); @(negedge clk);
    chk("R9 no load after restart byte", ld_cnt[1], 1);
    bus_wr(2'd1, 8'h33); @(negedge clk);
    chk("R9 write order restarted", ld_last[1], 16'h3322);
  endtask

  task automatic t_status;
    logic [7:0] d;
    out_i[1] = 1'b1;
    bus_wr(2'd3, 8'hD4);
    bus_rd(2'd1, d); chk("R10 status null set", d, 8'hF8);
    @(negedge clk); loaded_i[1] = 1'b1;
    @(negedge clk); loaded_i[1] = 1'b0;
    bus_wr(2'd3, 8'hD4);
    bus_rd(2'd1, d); chk("R10 status null cleared", d, 8'hB8);
    set_cnt(1, 16'hBEEF);
    bus_rd(2'd1, d); chk("R11 status read kept byte order", d, 8'hEF);
  endtask

  task automatic t_multi;
    logic [7:0] d;
    set_cnt(0, 16'h00A5); set_cnt(2, 16'hC300);
    bus_wr(2'd3, 8'hFA);
    set_cnt(0, 16'h1111); set_cnt(2, 16'h2222);
    bus_rd(2'd0, d); chk("R11 ch0 status first", d, 8'h54);
    bus_rd(2'd0, d); chk("R11 ch0 frozen count", d, 8'hA5);
    bus_rd(2'd2, d); chk("R11 ch2 status first", d, 8'h66);
    bus_rd(2'd2, d); chk("R11 ch2 frozen count", d, 8'hC3);
    bus_rd(2'd0, d); chk("R7 single-byte released", d, 8'h11);
  endtask

  task automatic t_misc;
    logic [7:0] d;
    bus_rd(2'd3, d); chk("R12 control read zero", d, 8'h00);
    set_cnt(0, 16'h0077);
    @(negedge clk); rd = 1; addr = 2'd0;
    @(negedge clk); rd = 0;
    chk("R12 read without select ignored", rdata, 8'h00);
    @(negedge clk); wr = 1; addr = 2'd0; wdata = 8'h99;
    @(negedge clk); wr = 0; @(negedge clk);
    chk("R12 write without select ignored", ld_cnt[0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_unconfigured;
    t_single_byte;
    t_pair;
    t_live_read;
    t_latch;
    t_reconfig;
    t_status;
    t_multi;
    t_misc;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule